// File: doc/BRIEF.md
# Device-0 Diagnostic Result Sequencer

This block runs the device-0 side of the execute-device-diagnostic command on an ATA-style drive. A write of the diagnostic opcode to the command register starts it. The block sets BSY and starts the local self-test through a start/done handshake, and the self-test returns an 8-bit result code. A strap input says whether a second device (device 1) sits on the cable.

When device 1 is present, the block watches that device's active-low pass line during a bounded window. The window starts when the command is accepted. The line goes through a synchroniser before it is sampled. If device 1 does not show a pass before the window closes, the block sets bit 7 of the posted code. When device 1 is absent, the local code is posted unchanged and there is no wait.

On completion, the block loads the error register, drops BSY and raises an interrupt request. The request stays up until the host reads the status register.

Top module: `devdiag_master`

## Requirements
- R1: After reset, `bsy`, `intrq` and `st_start` are 0 and `err_reg` is 8'h00.
- R2: A `cmd_we` pulse with `cmd_data` = 8'h90 while idle is accepted. One cycle later `bsy` is 1 and `st_start` is high for exactly that one cycle.
- R3: A command write carrying any opcode other than 8'h90 changes nothing. A command write made while `bsy` is 1 produces no further `st_start` pulse and does not alter the posted result.
- R4: The local code is taken from `st_code` in the cycle `st_done` is high. With `slave_present` = 0, `err_reg` is loaded with exactly that code, and no wait on `pdiag_n` takes place.
- R5: With `slave_present` = 1 and `pdiag_n` low while the window is open, `err_reg` equals the local code with bit 7 unchanged.
- R6: With `slave_present` = 1 and no `pdiag_n` low level inside the window of `TIMEOUT_CYC` cycles from acceptance, `err_reg` equals the local code ORed with 8'h80.
- R7: On completion, the new `err_reg` value, `bsy` = 0 and `intrq` = 1 all appear in the same cycle. `bsy` stays 1 from acceptance until that cycle.
- R8: `intrq` stays high until a cycle with `status_rd` high. It reads 0 in the following cycle.
- R9: `pdiag_n` passes through a two-stage synchroniser. A low level that is presented at least two clock edges before the window closes counts as a pass. A low level that first appears after the window has closed counts as a failure, even if the local test is still running.
- R10: A pass from device 1 that arrives while the local self-test is still running is remembered. It is used when the local test finishes, even if that happens after the window has closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_data | input | 8 | Opcode written with the strobe |
| status_rd | input | 1 | Host status-register read strobe; clears the interrupt |
| slave_present | input | 1 | Strap: 1 when device 1 is attached |
| pdiag_n | input | 1 | Asynchronous active-low pass line from device 1 |
| st_start | output | 1 | One-cycle pulse that starts the local self-test |
| st_done | input | 1 | Local self-test finished; `st_code` is valid |
| st_code | input | 8 | Local diagnostic result code |
| bsy | output | 1 | Status BSY bit |
| err_reg | output | 8 | Error register contents (diagnostic code) |
| intrq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 40 instead of the multi-second default. This lets a single run reach both a local self-test shorter than the window and one longer than it. It also brings within reach device-1 pass levels placed early, near the window's end and after it has closed. Every local code from 8'h00 to 8'h06 is run through each of these slave scenarios and through the absent-slave case. Each expected error-register value is computed in the bench from the acceptance cycle, the synchroniser delay and the window length.

// File: rtl/devdiag_pkg.sv
`timescale 1ns/1ps
package devdiag_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_SELFTEST = 2'd1,
    ST_WAIT     = 2'd2,
    ST_POST     = 2'd3
  } dd_state_e;

  localparam int unsigned CODE_W   = 8;
  localparam logic [CODE_W-1:0] OPC_DIAG  = 8'h90;
  localparam logic [CODE_W-1:0] SLAVE_BAD = 8'h80;

  // Posted diagnostic code: local result with the device-1 failure flag folded in.
  function automatic logic [CODE_W-1:0] merge_code(input logic [CODE_W-1:0] local_code,
                                                   input logic slave_fail);
    return local_code | (slave_fail ? SLAVE_BAD : '0);
  endfunction

endpackage

// File: rtl/devdiag_sync.sv
`timescale 1ns/1ps
module devdiag_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RESET_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/devdiag_window.sv
`timescale 1ns/1ps
module devdiag_window #(
  parameter int unsigned LIMIT = 1000,
  parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic open
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (arm)             remain <= CW'(LIMIT);
    else if (remain != '0)    remain <= remain - CW'(1);
  end

  assign open = (remain != '0);
endmodule

// File: rtl/devdiag_result.sv
`timescale 1ns/1ps
module devdiag_result
  import devdiag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CODE_W-1:0] code_in,
  input  logic              post,
  input  logic              slave_fail,
  input  logic              status_rd,
  output logic [CODE_W-1:0] local_code,
  output logic [CODE_W-1:0] err_reg,
  output logic              intrq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       local_code <= '0;
    else if (capture) local_code <= code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    err_reg <= '0;
    else if (post) err_reg <= merge_code(local_code, slave_fail);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         intrq <= 1'b0;
    else if (post)      intrq <= 1'b1;
    else if (status_rd) intrq <= 1'b0;
  end
endmodule

// File: rtl/devdiag_master.sv
`timescale 1ns/1ps
module devdiag_master
  import devdiag_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1_000_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  input  logic       status_rd,
  input  logic       slave_present,
  input  logic       pdiag_n,
  output logic       st_start,
  input  logic       st_done,
  input  logic [7:0] st_code,
  output logic       bsy,
  output logic [7:0] err_reg,
  output logic       intrq
);
  dd_state_e state, state_nx;

  // Named internal events, observed by the bound checker.
  logic accept_evt;
  logic post_evt;
  logic win_open;
  logic slave_seen;
  logic slave_fail;
  logic pass_held;
  logic [CODE_W-1:0] local_code;

  logic pdiag_s_n;
  logic fail_nx;
  logic ok_now;

  devdiag_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pdiag_n), .q(pdiag_s_n)
  );

  devdiag_window #(.LIMIT(TIMEOUT_CYC)) u_window (
    .clk(clk), .rst_n(rst_n), .arm(accept_evt), .open(win_open)
  );

  devdiag_result u_result (
    .clk(clk), .rst_n(rst_n),
    .capture(state == ST_SELFTEST && st_done), .code_in(st_code),
    .post(post_evt), .slave_fail(slave_fail), .status_rd(status_rd),
    .local_code(local_code), .err_reg(err_reg), .intrq(intrq)
  );

  assign accept_evt = (state == ST_IDLE) && cmd_we && (cmd_data == OPC_DIAG);
  assign post_evt   = (state == ST_POST);
  assign slave_seen = ~pdiag_s_n;
  assign ok_now     = pass_held | (slave_seen & win_open);

  always_comb begin
    state_nx = state;
    fail_nx  = slave_fail;
    unique case (state)
      ST_IDLE:     if (accept_evt) begin state_nx = ST_SELFTEST; fail_nx = 1'b0; end
      ST_SELFTEST: if (st_done) state_nx = slave_present ? ST_WAIT : ST_POST;
      ST_WAIT: begin
        if (ok_now) begin
          state_nx = ST_POST;
          fail_nx  = 1'b0;
        end else if (!win_open) begin
          state_nx = ST_POST;
          fail_nx  = 1'b1;
        end
      end
      ST_POST:     state_nx = ST_IDLE;
      default:     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      slave_fail <= 1'b0;
    end else begin
      state      <= state_nx;
      slave_fail <= fail_nx;
    end
  end

  // Sticky pass: a device-1 pass seen inside the window survives a long local test.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                            pass_held <= 1'b0;
    else if (accept_evt)                                   pass_held <= 1'b0;
    else if (state != ST_IDLE && slave_seen && win_open)   pass_held <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy      <= 1'b0;
      st_start <= 1'b0;
    end else begin
      st_start <= accept_evt;
      if (accept_evt)    bsy <= 1'b1;
      else if (post_evt) bsy <= 1'b0;
    end
  end
endmodule

// File: rtl/devdiag_checker.sv
`timescale 1ns/1ps
module devdiag_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       accept_evt,
  input logic       post_evt,
  input logic       slave_fail,
  input logic       win_open,
  input logic       st_start,
  input logic       bsy,
  input logic       intrq,
  input logic       status_rd,
  input logic [7:0] err_reg,
  input logic [7:0] local_code
);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (bsy && st_start));

  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    st_start |=> !st_start);

  a_r3_start_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    st_start |-> !$past(bsy));

  a_r4_pass_posts_local: assert property (@(posedge clk) disable iff (!rst_n)
    (post_evt && !slave_fail) |=> (err_reg == $past(local_code)));

  a_r6_fail_needs_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
    (post_evt && slave_fail) |-> !win_open);

  a_r7_irq_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intrq) |-> (!bsy && $past(post_evt)));

  a_r7_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && !post_evt) |=> bsy);

  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (intrq && !status_rd) |=> intrq);
endmodule

bind devdiag_master devdiag_checker u_chk (
  .clk(clk), .rst_n(rst_n), .accept_evt(accept_evt), .post_evt(post_evt),
  .slave_fail(slave_fail), .win_open(win_open), .st_start(st_start), .bsy(bsy),
  .intrq(intrq), .status_rd(status_rd), .err_reg(err_reg), .local_code(local_code)
);

// File: tb/devdiag_master_bench.sv
`timescale 1ns/1ps
module devdiag_master_bench;
  localparam int unsigned T = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       status_rd = 1'b0;
  logic       slave_present = 1'b0;
  logic       pdiag_n = 1'b1;
  logic       st_start;
  logic       st_done = 1'b0;
  logic [7:0] st_code = 8'h00;
  logic       bsy;
  logic [7:0] err_reg;
  logic       intrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  devdiag_master #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) u_devdiag_master (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .status_rd(status_rd), .slave_present(slave_present), .pdiag_n(pdiag_n),
    .st_start(st_start), .st_done(st_done), .st_code(st_code),
    .bsy(bsy), .err_reg(err_reg), .intrq(intrq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // pd_at: cycle after acceptance at which pdiag_n goes low (-1 = never).
  task automatic run_case(input logic [7:0] code, input bit present, input int pd_at,
                          input int dly, input string req);
    int  starts = 0;
    bit  got = 1'b0;
    bit  bsy_drop = 1'b0;
    bit  fail_exp;
    logic [7:0] exp_err;
    fail_exp = present && !(pd_at >= 0 && pd_at <= int'(T) - 3);
    exp_err  = code | (fail_exp ? 8'h80 : 8'h00);
    slave_present = present;
    cmd_we = 1'b1; cmd_data = 8'h90;
    @(posedge clk); #1;
    cmd_we = 1'b0;
    chk(bsy === 1'b1 && st_start === 1'b1, "R2 accept", {bsy, st_start}, 2'b11);
    for (int c = 0; c < 400 && !got; c++) begin
      if (c == pd_at) pdiag_n = 1'b0;
      if (c == 1) begin cmd_we = 1'b1; cmd_data = 8'h90; end
      if (c == 2) cmd_we = 1'b0;
      if (c == dly) begin st_done = 1'b1; st_code = code; end
      if (c == dly + 1) st_done = 1'b0;
      @(posedge clk); #1;
      if (st_start) starts++;
      if (intrq) got = 1'b1;
      else if (!bsy) bsy_drop = 1'b1;
    end
    st_done = 1'b0;
    cmd_we = 1'b0;
    chk(got, "R7 interrupt raised", got, 1);
    chk(!bsy_drop, "R7 busy held until done", bsy_drop, 0);
    chk(bsy === 1'b0, "R7 busy clear with interrupt", bsy, 0);
    chk(err_reg === exp_err, req, err_reg, exp_err);
    chk(starts == 0, "R3 busy write ignored", starts, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(intrq === 1'b1, "R8 interrupt held", intrq, 1);
    status_rd = 1'b1;
    @(posedge clk); #1;
    status_rd = 1'b0;
    chk(intrq === 1'b0, "R8 interrupt cleared by read", intrq, 0);
    pdiag_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(bsy === 1'b0 && intrq === 1'b0 && st_start === 1'b0, "R1 reset outputs",
        {bsy, intrq, st_start}, 0);
    chk(err_reg === 8'h00, "R1 reset error register", err_reg, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R3: a foreign opcode leaves the block idle.
    cmd_we = 1'b1; cmd_data = 8'hEC;
    @(posedge clk); #1;
    cmd_we = 1'b0;
    chk(bsy === 1'b0 && st_start === 1'b0, "R3 other opcode ignored", {bsy, st_start}, 0);
    @(posedge clk); #1;
    chk(bsy === 1'b0 && intrq === 1'b0, "R3 still idle", {bsy, intrq}, 0);

    for (int k = 0; k <= 6; k++) begin
      run_case(8'(k), 1'b0, 2,            3,  "R4 absent slave posts local code");
      run_case(8'(k), 1'b1, 2,            3,  "R5 early slave pass");
      run_case(8'(k), 1'b1, int'(T) - 6,  3,  "R9 pass near window end");
      run_case(8'(k), 1'b1, -1,           3,  "R6 slave silent");
      run_case(8'(k), 1'b1, int'(T) + 5,  3,  "R9 pass after window");
      run_case(8'(k), 1'b1, 2,            60, "R10 pass held over long self-test");
      run_case(8'(k), 1'b1, int'(T) + 5,  60, "R9 late pass during long self-test");
      run_case(8'(k), 1'b1, -1,           60, "R6 silent with long self-test");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule